// File: doc/BRIEF.md
# Relative Jump Resolver

This block decides whether a relative jump is taken and forms the next program counter. Each evaluation takes a 3-bit condition code, a signed word displacement, the address of the jump and the four arithmetic flags (carry, zero, negative, overflow). It returns a taken indication and the address where execution continues.

Conditions on equality read the zero flag. Unsigned orderings read the carry flag. Signed orderings compare the negative flag with the overflow flag. One code is always taken. The displacement counts 16-bit words. It is doubled and added to the address of the following word, so one instruction can reach from 511 words behind the jump to 512 words ahead of it.

A request is presented with `eval_en` high for one clock cycle. The result is registered and appears after that clock edge. It holds until the next request.

Top module: `branch_resolver`

## Requirements
- R1: While `rst_n` is low, and after it goes high with no request made, `taken` is 0 and `next_pc` is 0.
- R2: Code 1 (zero) is taken exactly when Z is 1. Code 0 (not zero) is taken exactly when Z is 0. The other flags do not affect either code.
- R3: Code 3 (carry, unsigned higher-or-same) is taken exactly when C is 1. Code 2 (no carry, unsigned lower) is taken exactly when C is 0. The other flags do not affect either code.
- R4: Code 4 (negative) is taken exactly when N is 1, whatever C, Z and V are.
- R5: Code 5 (signed greater-or-equal) is taken exactly when N equals V. Code 6 (signed less) is taken exactly when N differs from V. C and Z do not affect either code.
- R6: Code 7 is always taken, for all sixteen flag combinations.
- R7: When taken, `next_pc` equals `pc + 2 + 2*offset`, where `offset` is a two's-complement word count, and the sum wraps modulo 2^PC_W.
- R8: When not taken, `next_pc` equals `pc + 2` modulo 2^PC_W, whatever the offset is.
- R9: A request with `eval_en` high at a rising clock edge shows on `taken` and `next_pc` after that edge. While `eval_en` is low, both outputs hold their values.
- R10: The extreme offsets are handled as follows. Offset 0x1FF (+511) gives `pc + 1024` (512 words ahead). Offset 0x200 (-512) gives `pc - 1022` (511 words behind).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| eval_en | input | 1 | Evaluate the presented jump at this edge |
| cond | input | 3 | Condition code (0 nz, 1 z, 2 nc, 3 c, 4 n, 5 ge, 6 lt, 7 always) |
| offset | input | OFS_W (10) | Signed word displacement |
| pc | input | PC_W (16) | Byte address of the jump instruction |
| flag_c | input | 1 | Carry flag |
| flag_z | input | 1 | Zero flag |
| flag_n | input | 1 | Negative flag |
| flag_v | input | 1 | Overflow flag |
| taken | output | 1 | Registered: jump taken |
| next_pc | output | PC_W (16) | Registered: address of the next instruction |

## Verification
Every condition code is applied with all sixteen flag combinations. This confirms that each code reads only its own flag or flag pair, and it separates the unsigned codes from the signed ones. Random addresses and offsets are then applied. Taken jumps check the doubled, sign-extended displacement. Not-taken jumps check that the offset is ignored. Directed cases cover the largest forward and backward displacements, address wrap at both ends of the space, and outputs holding while no request is made.

// File: rtl/br_pkg.sv
package br_pkg;
  typedef enum logic [2:0] {
    CC_NZ = 3'd0,
    CC_Z  = 3'd1,
    CC_NC = 3'd2,
    CC_C  = 3'd3,
    CC_N  = 3'd4,
    CC_GE = 3'd5,
    CC_LT = 3'd6,
    CC_AL = 3'd7
  } cc_e;

  localparam int unsigned CC_COUNT = 8;

  // Predicate of one condition code on the four flags.
  function automatic logic cc_pred(input cc_e cc, input logic c, input logic z,
                                   input logic n, input logic v);
    logic r;
    unique case (cc)
      CC_NZ:   r = ~z;
      CC_Z:    r = z;
      CC_NC:   r = ~c;
      CC_C:    r = c;
      CC_N:    r = n;
      CC_GE:   r = ~(n ^ v);
      CC_LT:   r = n ^ v;
      default: r = 1'b1;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/br_cond_eval.sv
module br_cond_eval
  import br_pkg::*;
(
  input  logic [2:0] cond,
  input  logic       flag_c,
  input  logic       flag_z,
  input  logic       flag_n,
  input  logic       flag_v,
  output logic       hit
);
  logic [CC_COUNT-1:0] pred_vec;

  // One predicate per code, then a selection by the code.
  for (genvar g = 0; g < CC_COUNT; g++) begin : g_pred
    assign pred_vec[g] = cc_pred(cc_e'(g), flag_c, flag_z, flag_n, flag_v);
  end

  assign hit = pred_vec[cond];
endmodule

// File: rtl/br_target_calc.sv
module br_target_calc #(
  parameter int unsigned PC_W  = 16,
  parameter int unsigned OFS_W = 10
) (
  input  logic [PC_W-1:0]  pc,
  input  logic [OFS_W-1:0] offset,
  output logic [PC_W-1:0]  seq_pc,
  output logic [PC_W-1:0]  jump_pc
);
  localparam int unsigned EXT_W = PC_W - OFS_W - 1;

  // Word displacement sign-extended and doubled into a byte displacement.
  function automatic logic [PC_W-1:0] byte_disp(input logic [OFS_W-1:0] ofs);
    return {{EXT_W{ofs[OFS_W-1]}}, ofs, 1'b0};
  endfunction

  assign seq_pc  = pc + PC_W'(2);
  assign jump_pc = seq_pc + byte_disp(offset);
endmodule

// File: rtl/branch_resolver.sv
module branch_resolver #(
  parameter int unsigned PC_W  = 16,
  parameter int unsigned OFS_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             eval_en,
  input  logic [2:0]       cond,
  input  logic [OFS_W-1:0] offset,
  input  logic [PC_W-1:0]  pc,
  input  logic             flag_c,
  input  logic             flag_z,
  input  logic             flag_n,
  input  logic             flag_v,
  output logic             taken,
  output logic [PC_W-1:0]  next_pc
);
  logic            cond_hit;
  logic [PC_W-1:0] seq_pc;
  logic [PC_W-1:0] jump_pc;
  logic [PC_W-1:0] pc_sel;

  br_cond_eval u_cond (
    .cond   (cond),
    .flag_c (flag_c),
    .flag_z (flag_z),
    .flag_n (flag_n),
    .flag_v (flag_v),
    .hit    (cond_hit)
  );

  br_target_calc #(.PC_W(PC_W), .OFS_W(OFS_W)) u_tgt (
    .pc      (pc),
    .offset  (offset),
    .seq_pc  (seq_pc),
    .jump_pc (jump_pc)
  );

  assign pc_sel = cond_hit ? jump_pc : seq_pc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      taken   <= 1'b0;
      next_pc <= '0;
    end else if (eval_en) begin
      taken   <= cond_hit;
      next_pc <= pc_sel;
    end
  end
endmodule

// File: rtl/br_resolver_chk.sv
module br_resolver_chk #(
  parameter int unsigned PC_W  = 16,
  parameter int unsigned OFS_W = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             eval_en,
  input logic [2:0]       cond,
  input logic [OFS_W-1:0] offset,
  input logic [PC_W-1:0]  pc,
  input logic             flag_c,
  input logic             flag_z,
  input logic             flag_n,
  input logic             flag_v,
  input logic             taken,
  input logic [PC_W-1:0]  next_pc,
  input logic             cond_hit,
  input logic [PC_W-1:0]  seq_pc
);
  AST_ZERO_COND: assert property (@(posedge clk) disable iff (!rst_n)
    eval_en && cond == 3'd1 |=> taken == $past(flag_z)); // R2
  AST_CARRY_COND: assert property (@(posedge clk) disable iff (!rst_n)
    eval_en && cond == 3'd2 |=> taken == !$past(flag_c)); // R3
  AST_NEG_COND: assert property (@(posedge clk) disable iff (!rst_n)
    eval_en && cond == 3'd4 |=> taken == $past(flag_n)); // R4
  AST_SIGNED_LT: assert property (@(posedge clk) disable iff (!rst_n)
    eval_en && cond == 3'd6 |=> taken == ($past(flag_n) != $past(flag_v))); // R5
  AST_ALWAYS_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    eval_en && cond == 3'd7 |=> taken); // R6
  AST_SEQ_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    eval_en && !cond_hit |=> next_pc == $past(pc) + PC_W'(2)); // R8
  AST_SEQ_INTERNAL: assert property (@(posedge clk) disable iff (!rst_n)
    eval_en && !cond_hit |=> next_pc == $past(seq_pc)); // R8
  AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !eval_en |=> $stable(taken) && $stable(next_pc)); // R9
endmodule

bind branch_resolver br_resolver_chk #(.PC_W(PC_W), .OFS_W(OFS_W)) u_chk (.*);

// File: tb/tb_branch_resolver.sv
module tb_branch_resolver;
  localparam int unsigned PC_W  = 16;
  localparam int unsigned OFS_W = 10;
  localparam time CLK_PERIOD = 10ns;
  localparam int unsigned WATCHDOG = 50000;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             eval_en = 1'b0;
  logic [2:0]       cond = '0;
  logic [OFS_W-1:0] offset = '0;
  logic [PC_W-1:0]  pc = '0;
  logic             flag_c = 0, flag_z = 0, flag_n = 0, flag_v = 0;
  logic             taken;
  logic [PC_W-1:0]  next_pc;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  branch_resolver #(.PC_W(PC_W), .OFS_W(OFS_W)) dut (.*);

  // Expected decision written as a flag-selection table, not a code case.
  function automatic bit exp_taken(int cc, bit c, bit z, bit n, bit v);
    bit base;
    case (cc / 2)
      0: base = z;
      1: base = c;
      default: base = 1'b0;
    endcase
    if (cc < 4) return (cc % 2 == 1) ? base : !base;
    if (cc == 4) return n;
    if (cc == 5) return n == v;
    if (cc == 6) return n != v;
    return 1'b1;
  endfunction

  function automatic logic [PC_W-1:0] exp_pc(bit tk, logic [PC_W-1:0] p, logic [OFS_W-1:0] o);
    int words;
    words = (o >= (1 << (OFS_W-1))) ? int'(o) - (1 << OFS_W) : int'(o);
    if (!tk) words = 0;
    return PC_W'(int'(p) + 2 + 2 * words);
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic run_one(string req, int cc, logic [3:0] f, logic [PC_W-1:0] p,
                         logic [OFS_W-1:0] o);
    bit tk;
    @(negedge clk);
    eval_en = 1; cond = 3'(cc); pc = p; offset = o;
    {flag_c, flag_z, flag_n, flag_v} = f;
    @(negedge clk);
    eval_en = 0;
    tk = exp_taken(cc, f[3], f[2], f[1], f[0]);
    check(req, 32'(taken), 32'(tk));
    check(tk ? "R7" : "R8", 32'(next_pc), 32'(exp_pc(tk, p, o)));
  endtask

  initial begin
    for (int i = 0; i < WATCHDOG; i++) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    string tags[8];
    logic [PC_W-1:0] hold_pc;
    logic hold_tk;
    tags = '{"R2", "R2", "R3", "R3", "R4", "R5", "R5", "R6"};
    void'($urandom(32'd20240611));

    // R1: reset state, during and after reset
    repeat (3) @(negedge clk);
    check("R1", 32'(taken), 0);
    check("R1", 32'(next_pc), 0);
    rst_n = 1;
    @(negedge clk);
    check("R1", 32'(taken), 0);
    check("R1", 32'(next_pc), 0);

    // R2..R6: every code against every flag combination
    for (int cc = 0; cc < 8; cc++)
      for (int f = 0; f < 16; f++)
        run_one(tags[cc], cc, 4'(f), PC_W'($urandom), OFS_W'($urandom));

    // R10: extreme displacements
    run_one("R10", 7, 4'h0, 16'h4000, 10'h1FF);
    check("R10", 32'(next_pc), 32'h4400);
    run_one("R10", 7, 4'h0, 16'h4000, 10'h200);
    check("R10", 32'(next_pc), 32'h3C02);
    // R7: wrap at both ends of the address space
    run_one("R7", 7, 4'h0, 16'hFFFE, 10'h001);
    check("R7", 32'(next_pc), 32'h0002);
    run_one("R7", 7, 4'h0, 16'h0000, 10'h3FE);
    check("R7", 32'(next_pc), 32'hFFFE);
    // R8: not taken ignores offset, including extremes
    run_one("R8", 1, 4'h0, 16'h1234, 10'h200);
    check("R8", 32'(next_pc), 32'h1236);
    run_one("R8", 0, 4'h4, 16'hFFFE, 10'h1FF);
    check("R8", 32'(next_pc), 32'h0000);

    // R9: outputs hold while eval_en is low
    run_one("R9", 7, 4'h0, 16'h0100, 10'h010);
    hold_pc = next_pc; hold_tk = taken;
    cond = 3'd0; flag_z = 1; pc = 16'hAAAA; offset = 10'h155;
    repeat (4) @(negedge clk);
    check("R9", 32'(taken), 32'(hold_tk));
    check("R9", 32'(next_pc), 32'(hold_pc));

    // Random mix
    for (int i = 0; i < 400; i++) begin
      int cc;
      cc = int'($urandom % 8);
      run_one(tags[cc], cc, 4'($urandom), PC_W'($urandom), OFS_W'($urandom));
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule